// File: doc/BRIEF.md
# Byte-to-Word Memory Access Bridge

This block joins an 8-bit host transfer channel to a memory whose words are 16 bits wide. The host issues single-byte requests with a byte address, a direction, a mode bit and write data. The bridge answers each request with a one-cycle completion pulse, and with a read byte for a read. Toward the memory it drives a word engine that accepts only whole-word reads and whole-word writes. The bridge holds each engine request until that engine acknowledges it.

The block has two modes, and the mode bit is taken with each request. In word mode, two successive word-mode transfers form one memory word. The first byte is the low half and the second is the high half. A small holding register carries the other half between the two transfers. One transfer of each pair touches memory and the other only loads or unloads the holding register. In byte mode, bit 0 of the byte address picks the half of the word. A byte read is a single word read. A byte write is a read-modify-write: the bridge reads the word, replaces the addressed half and writes the whole word back.

A request that arrives while a sequence is running waits in a one-entry slot and starts when that sequence ends.

Top module: `b2w_bridge`

## Requirements
- R1: After reset, `host_done` and `mem_req` are low and the pair phase is cleared, so the first word-mode transfer is taken as the low byte.
- R2: Word-mode write: the first byte causes no memory access. The second causes exactly one memory write of {second, first} to word address `host_addr[ADDR_W-1:1]`. Bit 0 of the address is ignored in word mode.
- R3: Word-mode read: the first byte causes one memory read and returns bits 7:0. The second returns bits 15:8 of that word and causes no memory access.
- R4: Byte-mode read performs one memory read and returns bits 7:0 when `host_addr[0]`=0 and bits 15:8 when `host_addr[0]`=1.
- R5: Byte-mode write performs one memory read followed by one memory write. In the written word only the addressed half changes, and the other half keeps its stored value.
- R6: Every memory request has both byte enables set (`mem_be` = 2'b11).
- R7: `host_done` is a one-cycle pulse. It is raised only after the last memory acknowledge of the sequence, with `mem_req` low.
- R8: A request that arrives while a sequence is busy is held and served afterwards. Requests complete in arrival order.
- R9: The mode is taken per request. Byte-mode transfers do not advance the word-mode pair phase, so a word pair may be split by byte transfers.
- R10: Once raised, `mem_req` stays high with stable address, direction and data until `mem_ack`. `mem_ack` is a one-cycle pulse per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | One-cycle request strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_word | input | 1 | 1 = word mode, 0 = byte mode |
| host_addr | input | ADDR_W | Byte address |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, valid with `host_done` |
| host_done | output | 1 | Completion pulse |
| mem_req | output | 1 | Word engine request |
| mem_we | output | 1 | Word engine write |
| mem_addr | output | ADDR_W-1 | Word address |
| mem_wdata | output | 16 | Word write data |
| mem_be | output | 2 | Byte enables, always both |
| mem_rdata | input | 16 | Word read data, valid with `mem_ack` |
| mem_ack | input | 1 | Word engine acknowledge |

## Verification
The bench builds the bridge with `ADDR_W` = 6, which gives 64 byte addresses over 32 words. At that size every byte address can be swept in byte mode and every word can be swept in word mode, with expected bytes computed from the address. A behavioural word memory answers after a fixed delay and counts its reads and writes. Those counts show that the dummy halves of a word pair never reach memory and that a byte write costs exactly one read and one write. The small space also makes short tests practical for pairs split by byte transfers and for back-to-back requests that arrive while the bridge is busy.

// File: rtl/b2w_pkg.sv
package b2w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DUMMY = 3'd1,
    ST_MRD   = 3'd2,
    ST_MWR   = 3'd3,
    ST_FIN   = 3'd4
  } ctl_state_t;

  function automatic logic [15:0] put_byte(input logic [15:0] w,
                                           input logic [7:0]  b,
                                           input logic        up);
    return up ? {b, w[7:0]} : {w[15:8], b};
  endfunction

  function automatic logic [7:0] get_byte(input logic [15:0] w,
                                          input logic        up);
    return up ? w[15:8] : w[7:0];
  endfunction
endpackage

// File: rtl/b2w_slot.sv
module b2w_slot #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              in_we,
  input  logic              in_word,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [7:0]        in_wdata,
  input  logic              pop,
  output logic              v_q,
  output logic              we_q,
  output logic              word_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [7:0]        wdata_q
);
  logic v_d;

  always_comb begin
    v_d = v_q;
    if (pop)  v_d = 1'b0;
    if (push) v_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      word_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (push) begin
      we_q    <= in_we;
      word_q  <= in_word;
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
    end
  end

  // R8: the controller takes a request only from a filled slot
  a_r8_pop_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> v_q);
  // R8: a waiting request is kept until it is taken
  a_r8_keep_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && !pop) |=> v_q);
endmodule

// File: rtl/b2w_hold.sv
module b2w_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_en,
  input  logic [7:0] ld_val,
  input  logic       ph_tog,
  output logic [7:0] hold_q,
  output logic       phase_q
);
  logic [7:0] hold_d;
  logic       phase_d;

  always_comb begin
    hold_d  = ld_en  ? ld_val   : hold_q;
    phase_d = ph_tog ? ~phase_q : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      phase_q <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      phase_q <= phase_d;
    end
  end

  // R9: the pair phase moves only on a word-mode completion
  a_r9_phase_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_tog |=> $stable(phase_q));
  a_r3_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
    ph_tog |=> (phase_q != $past(phase_q)));
endmodule

// File: rtl/b2w_ctrl.sv
module b2w_ctrl
  import b2w_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int WA_W  = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_v,
  input  logic              s_we,
  input  logic              s_word,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [7:0]        s_wdata,
  output logic              pop,
  input  logic              phase,
  input  logic [7:0]        hold_q,
  output logic              hold_ld,
  output logic [7:0]        hold_val,
  output logic              ph_tog,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WA_W-1:0]   mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_ack,
  output logic [7:0]        host_rdata,
  output logic              host_done
);
  ctl_state_t        st_q, st_d;
  logic              we_q, we_d, word_q, word_d, ph_q, ph_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        wd_q, wd_d, rd_q, rd_d;
  logic [15:0]       wbuf_q, wbuf_d;

  always_comb begin
    st_d     = st_q;
    we_d     = we_q;
    word_d   = word_q;
    ph_d     = ph_q;
    addr_d   = addr_q;
    wd_d     = wd_q;
    rd_d     = rd_q;
    wbuf_d   = wbuf_q;
    pop      = 1'b0;
    hold_ld  = 1'b0;
    hold_val = 8'h00;
    ph_tog   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (s_v) begin
        pop    = 1'b1;
        we_d   = s_we;
        word_d = s_word;
        ph_d   = phase;
        addr_d = s_addr;
        wd_d   = s_wdata;
        if (s_word) begin
          if (s_we && phase) begin
            wbuf_d = {s_wdata, hold_q};
            st_d   = ST_MWR;
          end else if (!s_we && !phase) st_d = ST_MRD;
          else                          st_d = ST_DUMMY;
        end else begin
          st_d = ST_MRD;
        end
      end
      ST_DUMMY: begin
        if (we_q) begin
          hold_ld  = 1'b1;
          hold_val = wd_q;
        end else begin
          rd_d = hold_q;
        end
        st_d = ST_FIN;
      end
      ST_MRD: if (mem_ack) begin
        if (we_q) begin
          wbuf_d = put_byte(mem_rdata, wd_q, addr_q[0]);
          st_d   = ST_MWR;
        end else begin
          if (word_q) begin
            rd_d     = mem_rdata[7:0];
            hold_ld  = 1'b1;
            hold_val = mem_rdata[15:8];
          end else begin
            rd_d = get_byte(mem_rdata, addr_q[0]);
          end
          st_d = ST_FIN;
        end
      end
      ST_MWR: if (mem_ack) st_d = ST_FIN;
      ST_FIN: begin
        ph_tog = word_q;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      we_q   <= 1'b0;
      word_q <= 1'b0;
      ph_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      wbuf_q <= '0;
    end else begin
      st_q   <= st_d;
      we_q   <= we_d;
      word_q <= word_d;
      ph_q   <= ph_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
      rd_q   <= rd_d;
      wbuf_q <= wbuf_d;
    end
  end

  assign mem_req    = (st_q == ST_MRD) || (st_q == ST_MWR);
  assign mem_we     = (st_q == ST_MWR);
  assign mem_addr   = addr_q[ADDR_W-1:1];
  assign mem_wdata  = wbuf_q;
  assign host_rdata = rd_q;
  assign host_done  = (st_q == ST_FIN);

  // R10: request, address, direction and data hold until acknowledge
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));
  // R7: completion is signalled with the engine idle
  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |-> !mem_req);
  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);
  // R5: the read of a byte write is followed by the write-back
  a_r5_rmw_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && we_q && mem_ack) |=> (mem_req && mem_we));
  // R2: the dummy half of a word pair issues no memory request
  a_r2_dummy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ld && we_q) |-> !mem_req);
endmodule

// File: rtl/b2w_bridge.sv
module b2w_bridge #(
  parameter int ADDR_W = 16,
  localparam int WA_W  = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic              host_word,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              host_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WA_W-1:0]   mem_addr,
  output logic [15:0]       mem_wdata,
  output logic [1:0]        mem_be,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_ack
);
  logic              rst_s1, rst_sn;
  logic              s_v, s_we, s_word, pop;
  logic [ADDR_W-1:0] s_addr;
  logic [7:0]        s_wdata, hold_q, hold_val;
  logic              phase, hold_ld, ph_tog;

  // reset asserts at once and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  b2w_slot #(.ADDR_W(ADDR_W)) i_slot (
    .clk(clk), .rst_n(rst_sn), .push(host_req),
    .in_we(host_we), .in_word(host_word), .in_addr(host_addr),
    .in_wdata(host_wdata), .pop(pop), .v_q(s_v), .we_q(s_we),
    .word_q(s_word), .addr_q(s_addr), .wdata_q(s_wdata)
  );

  b2w_hold i_hold (
    .clk(clk), .rst_n(rst_sn), .ld_en(hold_ld), .ld_val(hold_val),
    .ph_tog(ph_tog), .hold_q(hold_q), .phase_q(phase)
  );

  b2w_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rst_n(rst_sn), .s_v(s_v), .s_we(s_we), .s_word(s_word),
    .s_addr(s_addr), .s_wdata(s_wdata), .pop(pop), .phase(phase),
    .hold_q(hold_q), .hold_ld(hold_ld), .hold_val(hold_val),
    .ph_tog(ph_tog), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .host_rdata(host_rdata), .host_done(host_done)
  );

  // partial updates are resolved here, so the engine always sees full words
  assign mem_be = 2'b11;
endmodule

// File: tb/test_b2w_bridge.sv
module test_b2w_bridge;
  localparam int AW  = 6;
  localparam int NW  = 1 << (AW - 1);
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_req = 1'b0, host_we = 1'b0, host_word = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [7:0]    host_wdata = '0;
  logic [7:0]    host_rdata;
  logic          host_done, mem_req, mem_we;
  logic [AW-2:0] mem_addr;
  logic [15:0]   mem_wdata;
  logic [1:0]    mem_be;
  logic [15:0]   mem_rdata = '0;
  logic          mem_ack = 1'b0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int nrd = 0, nwr = 0, be_bad = 0, drop_bad = 0;
  logic [15:0] mem [NW];
  int lcnt = 0;
  logic prev_req = 1'b0, prev_ack = 1'b0;

  always #5 clk = ~clk;

  b2w_bridge #(.ADDR_W(AW)) i_b2w_bridge (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_word(host_word), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_done(host_done), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // behavioural full-word memory engine
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      if (mem_be != 2'b11) be_bad++;
      if (lcnt == LAT) begin
        lcnt = 0;
        mem_ack <= 1'b1;
        if (mem_we) begin mem[mem_addr] = mem_wdata; nwr++; end
        else begin mem_rdata <= mem[mem_addr]; nrd++; end
      end else lcnt++;
    end else mem_ack <= 1'b0;
    if (prev_req && !prev_ack && !mem_req) drop_bad++;
    prev_req = mem_req;
    prev_ack = mem_ack;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic start(input bit we, input bit wm, input int a, input int d);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_word = wm;
    host_addr = AW'(a); host_wdata = 8'(d);
  endtask

  task automatic wait_done(output logic [7:0] q);
    while (!host_done) @(negedge clk);
    q = host_rdata;
    chk(!mem_req, "R7 done with engine idle", int'(mem_req), 0);
    @(negedge clk);
    chk(!host_done, "R7 done is one cycle", int'(host_done), 0);
  endtask

  task automatic xfer(input bit we, input bit wm, input int a, input int d,
                      output logic [7:0] q);
    start(we, wm, a, d);
    @(negedge clk);
    host_req = 1'b0;
    wait_done(q);
  endtask

  function automatic int fb(input int a); return (a * 37 + 5) & 8'hff; endfunction
  function automatic int gw(input int w); return (w * 13 + 1) & 8'hff; endfunction

  initial begin
    logic [7:0] q, q2;
    int r0, w0;
    for (int i = 0; i < NW; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    chk(!host_done && !mem_req, "R1 reset outputs", {host_done, mem_req}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!host_done && !mem_req, "R1 idle after reset", {host_done, mem_req}, 0);

    // R1/R2: first word-mode byte after reset is the low half
    r0 = nrd; w0 = nwr;
    xfer(1, 1, 10, 8'h11, q);
    chk(nrd == r0 && nwr == w0, "R2 first byte no access", nrd + nwr, r0 + w0);
    xfer(1, 1, 11, 8'h22, q);
    chk(nwr == w0 + 1 && nrd == r0, "R2 one write", nwr, w0 + 1);
    chk(mem[5] == 16'h2211, "R1 R2 pair order", mem[5], 16'h2211);

    // R5: byte write sweep, one read then one write each
    for (int a = 0; a < 2 * NW; a++) begin
      r0 = nrd; w0 = nwr;
      xfer(1, 0, a, fb(a), q);
      chk(nrd == r0 + 1 && nwr == w0 + 1, "R5 rmw access count",
          (nrd - r0) * 16 + (nwr - w0), 16'h11);
    end
    for (int w = 0; w < NW; w++)
      chk(mem[w] == {8'(fb(2*w+1)), 8'(fb(2*w))}, "R5 merged word",
          mem[w], {8'(fb(2*w+1)), 8'(fb(2*w))});

    // R3: word read sweep
    for (int w = 0; w < NW; w++) begin
      r0 = nrd;
      xfer(0, 1, 2 * w + 1, 0, q);
      chk(q == 8'(fb(2*w)) && nrd == r0 + 1, "R3 first byte low", q, fb(2*w));
      xfer(0, 1, 2 * w, 0, q);
      chk(q == 8'(fb(2*w+1)) && nrd == r0 + 1, "R3 second byte high", q, fb(2*w+1));
    end

    // R2: word write sweep
    for (int w = 0; w < NW; w++) begin
      xfer(1, 1, 2 * w, gw(w), q);
      xfer(1, 1, 2 * w, 255 - gw(w), q);
      chk(mem[w] == {8'(255 - gw(w)), 8'(gw(w))}, "R2 word write", mem[w],
          {8'(255 - gw(w)), 8'(gw(w))});
    end

    // R4: byte read sweep
    for (int a = 0; a < 2 * NW; a++) begin
      r0 = nrd;
      xfer(0, 0, a, 0, q);
      chk(q == ((a & 1) ? 8'(255 - gw(a / 2)) : 8'(gw(a / 2))) && nrd == r0 + 1,
          "R4 byte read", q, (a & 1) ? 255 - gw(a / 2) : gw(a / 2));
    end

    // R5: other half preserved
    for (int w = 0; w < NW; w += 3) begin
      xfer(1, 0, 2 * w + 1, 8'hA5, q);
      chk(mem[w] == {8'hA5, 8'(gw(w))}, "R5 low half kept", mem[w], {8'hA5, 8'(gw(w))});
      xfer(1, 0, 2 * w, 8'h5A, q);
      chk(mem[w] == 16'hA55A, "R5 high half kept", mem[w], 16'hA55A);
    end

    // R9: a word pair split by byte transfers
    xfer(1, 1, 6, 8'h3C, q);
    xfer(0, 0, 20, 0, q);
    xfer(1, 0, 21, 8'h77, q);
    xfer(1, 1, 7, 8'hC3, q);
    chk(mem[3] == 16'hC33C, "R9 split pair", mem[3], 16'hC33C);
    chk(mem[10][15:8] == 8'h77, "R9 byte op in pair", mem[10][15:8], 8'h77);

    // R8: back-to-back requests while busy
    start(1, 0, 0, 8'h5A);
    start(1, 0, 1, 8'hC3);
    @(negedge clk); host_req = 1'b0;
    wait_done(q);
    wait_done(q);
    chk(mem[0] == 16'hC35A, "R8 both writes served", mem[0], 16'hC35A);
    start(0, 0, 1, 0);
    start(0, 0, 0, 0);
    @(negedge clk); host_req = 1'b0;
    wait_done(q);
    wait_done(q2);
    chk(q == 8'hC3 && q2 == 8'h5A, "R8 order kept", {q, q2}, 16'hC35A);

    chk(be_bad == 0, "R6 full byte enables", be_bad, 0);
    chk(drop_bad == 0, "R10 request held to ack", drop_bad, 0);
    finish_run();
  end
endmodule